// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit binary-coded decimal digit into the seven segment drives of a common-cathode display. A lit segment is a logic 1. A clocked holding register sits in front of the decode table. While the active-low hold control is low, the register reloads on every clock, so the display follows the input one cycle later. When the control goes high, the register keeps the last code it loaded, and the display stays fixed until the control returns low.

Two active-low overrides act after the register and before the outputs, within the same cycle. Lamp test lights all seven segments and ranks above everything else. Blanking darkens all seven segments when lamp test is inactive. Neither override changes the stored code, so releasing an override shows the digit that was held or passing through. The six codes above nine produce a dark display.

Top module: `segdec_top`

## Requirements
- R1: At a rising clock edge where hold_n is 0 and rst is 0, the stored code takes the value of bcd_in. From that edge on, seg shows the decode of that code, provided no override is active.
- R2: At a rising clock edge where hold_n is 1, the stored code keeps its value. Changes on bcd_in then have no effect on seg.
- R3: While test_n is 0, seg is 7'b1111111 in the same cycle, whatever hold_n, blank_n, bcd_in and the stored code are.
- R4: While test_n is 1 and blank_n is 0, seg is 7'b0000000 in the same cycle.
- R5: blank_n and test_n never change the stored code. Once both are 1 again, seg shows the decode of the code that was held or loaded meanwhile.
- R6: A stored code from 10 to 15, with both overrides inactive, gives seg = 7'b0000000.
- R7: seg is ordered {g,f,e,d,c,b,a}. The digit patterns are 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111100 (no top bar), 7=0000111, 8=1111111 and 9=1100111 (no bottom bar).
- R8: A rising clock edge with rst at 1 clears the stored code to 0, so seg then shows 0111111 when no override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | BCD digit to display |
| hold_n | input | 1 | Low: register reloads each clock; high: code is kept |
| blank_n | input | 1 | Active-low blanking override |
| test_n | input | 1 | Active-low lamp test override |
| seg | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |

## Verification
Both overrides can be asserted in the same cycle. They can also land on the cycle in which hold_n rises and a code is captured. The bench drives lamp test and blanking together, over both valid and invalid held codes, and expects all segments lit, because lamp test ranks first. It then raises hold_n while an override is active and changes bcd_in. After the overrides are released, the display must show the code captured at the rising edge and not the later inputs.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  typedef enum logic [1:0] {
    OVR_NONE  = 2'd0,
    OVR_BLANK = 2'd1,
    OVR_LAMP  = 2'd2
  } ovr_e;

  // Segment order {g,f,e,d,c,b,a}; codes above nine are dark.
  function automatic seg_t bcd_to_seg(code_t c);
    seg_t s;
    case (c)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111100;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1100111;
      default: s = '0;
    endcase
    return s;
  endfunction

  // Lamp test outranks blanking.
  function automatic ovr_e pick_ovr(logic test_n, logic blank_n);
    if (!test_n)       return OVR_LAMP;
    else if (!blank_n) return OVR_BLANK;
    else               return OVR_NONE;
  endfunction
endpackage

// File: rtl/segdec_hold.sv
module segdec_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/segdec_rom.sv
module segdec_rom
  import segdec_pkg::*;
(
  input  code_t code,
  output seg_t  pattern,
  output logic  code_valid
);
  always_comb begin
    pattern    = bcd_to_seg(code);
    code_valid = (int'(code) <= MAX_DIGIT);
  end
endmodule

// File: rtl/segdec_override.sv
module segdec_override
  import segdec_pkg::*;
(
  input  seg_t pattern,
  input  ovr_e sel,
  output seg_t seg
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    always_comb begin
      unique case (sel)
        OVR_LAMP:  seg[i] = 1'b1;
        OVR_BLANK: seg[i] = 1'b0;
        default:   seg[i] = pattern[i];
      endcase
    end
  end
endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcd_in,
  input  logic       hold_n,
  input  logic       blank_n,
  input  logic       test_n,
  output logic [6:0] seg
);
  code_t held_code;
  seg_t  raw_pattern;
  logic  code_valid;
  ovr_e  ovr_sel;
  logic  load_en;

  assign load_en = ~hold_n;
  assign ovr_sel = pick_ovr(test_n, blank_n);

  segdec_hold #(.W(CODE_W)) u_hold (
    .clk(clk), .rst(rst), .load_en(load_en), .d(bcd_in), .q(held_code)
  );

  segdec_rom u_rom (
    .code(held_code), .pattern(raw_pattern), .code_valid(code_valid)
  );

  segdec_override u_ovr (
    .pattern(raw_pattern), .sel(ovr_sel), .seg(seg)
  );
endmodule

// File: rtl/segdec_chk.sv
module segdec_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] bcd_in,
  input logic       hold_n,
  input logic       blank_n,
  input logic       test_n,
  input logic [3:0] held,
  input logic       code_valid,
  input logic [6:0] seg
);
  a_r1_load_follows: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> held == $past(bcd_in));

  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    hold_n |=> $stable(held));

  a_r3_lamp_all_on: assert property (@(posedge clk) disable iff (rst)
    !test_n |-> seg == 7'h7F);

  a_r4_blank_all_off: assert property (@(posedge clk) disable iff (rst)
    (test_n && !blank_n) |-> seg == 7'h00);

  a_r6_invalid_dark: assert property (@(posedge clk) disable iff (rst)
    (test_n && blank_n && !code_valid) |-> seg == 7'h00);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> held == 4'd0);
endmodule

bind segdec_top segdec_chk u_chk (
  .clk(clk), .rst(rst), .bcd_in(bcd_in), .hold_n(hold_n),
  .blank_n(blank_n), .test_n(test_n), .held(held_code),
  .code_valid(code_valid), .seg(seg)
);

// File: tb/test_segdec_top.sv
module test_segdec_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = '0;
  logic       hold_n = 1'b0;
  logic       blank_n = 1'b1;
  logic       test_n = 1'b1;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_held = '0;
  bit done = 0;

  segdec_top i_segdec_top (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .hold_n(hold_n),
    .blank_n(blank_n), .test_n(test_n), .seg(seg)
  );

  always #4 clk = ~clk;

  function automatic logic [6:0] digit_pat(logic [3:0] c);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7C, 7'h07, 7'h7F, 7'h67};
    if (c > 4'd9) return 7'h00;
    return t[c];
  endfunction

  function automatic logic [6:0] exp_seg(logic [3:0] c, logic t, logic b);
    if (!t) return 7'h7F;
    if (!b) return 7'h00;
    return digit_pat(c);
  endfunction

  task automatic check(string req, logic [6:0] exp);
    checks++;
    if (seg !== exp) begin
      errors++;
      $display("FAIL %s seg=%b expected=%b (held model %0d)", req, seg, exp, m_held);
    end
  endtask

  // drive at negedge, model the edge, sample 2 ns after the rising edge
  task automatic cyc(logic [3:0] d, logic h, logic b, logic t);
    @(negedge clk);
    bcd_in = d; hold_n = h; blank_n = b; test_n = t;
    @(posedge clk);
    if (rst) m_held = '0;
    else if (!h) m_held = d;
    #2;
  endtask

  task automatic set_ovr(logic b, logic t);
    blank_n = b; test_n = t;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    cyc(4'd7, 1'b0, 1'b1, 1'b1);
    cyc(4'd7, 1'b0, 1'b1, 1'b1);
    check("R8 reset shows zero", 7'h3F);
    @(negedge clk); rst = 1'b0;

    // R1/R7/R6: every code in transparent mode
    for (int c = 0; c < 16; c++) begin
      cyc(4'(c), 1'b0, 1'b1, 1'b1);
      check(c > 9 ? "R6 invalid code dark" : "R1 R7 transparent digit", exp_seg(4'(c), 1'b1, 1'b1));
    end

    // R2: capture 3, then change inputs with hold high
    cyc(4'd3, 1'b0, 1'b1, 1'b1);
    cyc(4'd5, 1'b1, 1'b1, 1'b1);
    check("R2 captured code kept", 7'h4F);
    cyc(4'd8, 1'b1, 1'b1, 1'b1);
    check("R2 input ignored while held", 7'h4F);

    // R3/R4/R5 override combinations on held code 3
    set_ovr(1'b0, 1'b1); check("R4 blanking", 7'h00);
    set_ovr(1'b1, 1'b0); check("R3 lamp test", 7'h7F);
    set_ovr(1'b0, 1'b0); check("R3 lamp outranks blanking", 7'h7F);
    set_ovr(1'b1, 1'b1); check("R5 release shows held", 7'h4F);

    // R5: capture edge while both overrides active
    cyc(4'd6, 1'b0, 1'b0, 1'b0);
    check("R3 lamp during load", 7'h7F);
    cyc(4'd2, 1'b1, 1'b0, 1'b0);
    cyc(4'd9, 1'b1, 1'b0, 1'b1);
    check("R4 blank while held", 7'h00);
    set_ovr(1'b1, 1'b1); check("R5 code captured under override", 7'h7C);

    // R3 over invalid held code
    cyc(4'd12, 1'b0, 1'b1, 1'b1);
    check("R6 held 12 dark", 7'h00);
    set_ovr(1'b1, 1'b0); check("R3 lamp on invalid code", 7'h7F);
    set_ovr(1'b1, 1'b1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d;
      logic h, b, t;
      d = 4'($urandom);
      h = ($urandom % 3) == 0;
      b = ($urandom % 4) != 0;
      t = ($urandom % 5) != 0;
      cyc(d, h, b, t);
      check("R1 R2 R3 R4 random", exp_seg(m_held, t, b));
    end

    // R8 reset mid-run
    @(negedge clk); rst = 1'b1;
    cyc(4'd4, 1'b1, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0;
    #1 check("R8 reset clears held code", 7'h3F);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule